// File: doc/BRIEF.md
# Cache-Line Burst Memory Controller

This block sits on the memory side of a synchronous 32-bit processor bus and answers every access from a small on-chip word array with a one-cycle read latency. Each access is terminated synchronously and is always a full 32 bits wide. A plain read or write takes two bus clocks. The first is the clock in which the controller sees the strobes. The second is the clock in which it returns the termination acknowledge.

When the processor fills a cache line, it raises a burst request together with the strobes. The controller may then grant a burst. It does so only for reads that fall inside a configured burstable address window, and it signals the grant with a burst acknowledge during the second clock of the first word. Once a burst is granted, the other words of the line follow on consecutive clocks, one clock per word. The words are taken in wrapping order inside the aligned line, starting at the word that was asked for. A four-word line therefore takes 5 clocks instead of 8.

If the processor withdraws the burst request or drops the address strobe partway through, the controller stops acknowledging on the next clock and goes idle.

Top module: `burst_mem_ctrl`

## Requirements
- R1: Reset state: while reset is held and right after it, term_ack, burst_ack and rd_data are all zero.
- R2: A read to byte address A returns, in its second clock, with term_ack high, the 32-bit word most recently written to the same word index A[7:2]. Bits above the array are ignored.
- R3: A write stores bus_wdata at word index A[7:2] and is acknowledged in its second clock. term_ack is high for exactly that one clock and burst_ack stays low.
- R4: A non-burst access gives exactly one term_ack clock, and term_ack is low in the clock after it.
- R5: burst_ack rises in the second clock of an access if and only if the access is a read, bus_burst_req was high in its first clock, and A lies in [BURST_LO, BURST_HI]. The default window is 0x00 to 0x7F.
- R6: A granted burst gives four term_ack clocks in a row, so a four-word line completes in 5 clocks.
- R7: Within a burst, beat k returns the word at line offset (A[3:2] + k) mod 4 inside the 16-byte-aligned line.
- R8: When a fill is not granted, the processor re-issues each word as a separate two-clock read, and the line takes 8 clocks.
- R9: If bus_as or bus_burst_req is sampled low at the end of a burst acknowledge clock, the next clock has term_ack low and rd_data zero, and no more beats follow.
- R10: rd_data is zero in every clock that does not acknowledge a read.
- R11: burst_ack stays high in every acknowledge clock of a granted burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_burst_req | input | 1 | Processor requests a line burst |
| rd_data | output | 32 | Read data, zero when not acknowledging a read |
| term_ack | output | 1 | Synchronous termination acknowledge |
| burst_ack | output | 1 | Burst granted / beat of a burst |

## Verification
The case that is hardest to reach from the ports is a burst cut short in its middle beats. The processor has to keep its strobes up through the grant and then withdraw the request exactly one clock into the fast beats. Directed sequences produce that withdrawal after the first beat, and also a strobe drop right at the grant clock. Random line fills that start at every offset in the line, some inside the burstable window and some outside it, then cover both wrap ordering and the fallback timing.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FIRST = 2'd1,
      ST_BEAT  = 2'd2
   } bmc_state_e;
endpackage

// File: rtl/bmc_addr_gen.sv
// Wrapping word address inside an aligned line.
module bmc_addr_gen #(
   parameter int MEM_AW    = 6,
   parameter int LINE_BITS = 2
) (
   input  logic [MEM_AW-1:0]    base_word,
   input  logic [LINE_BITS-1:0] offset,
   output logic [MEM_AW-1:0]    word
);
   logic [LINE_BITS-1:0] low_sum;

   always_comb low_sum = base_word[LINE_BITS-1:0] + offset;

   generate
      if (MEM_AW > LINE_BITS) begin : g_upper
         assign word = {base_word[MEM_AW-1:LINE_BITS], low_sum};
      end else begin : g_line_only
         assign word = low_sum;
      end
   endgenerate
endmodule

// File: rtl/bmc_range_chk.sv
// Decides whether an address may be served as a burst.
module bmc_range_chk #(
   parameter int          AW       = 32,
   parameter bit          BURST_EN = 1'b1,
   parameter logic [31:0] LO       = 32'h0000_0000,
   parameter logic [31:0] HI       = 32'h0000_007F
) (
   input  logic [AW-1:0] addr,
   output logic          burstable
);
   generate
      if (!BURST_EN) begin : g_off
         assign burstable = 1'b0;
      end else begin : g_window
         logic [31:0] a32;
         always_comb begin
            a32 = '0;
            a32[AW-1:0] = addr;
         end
         assign burstable = (a32 >= LO) && (a32 <= HI);
      end
   endgenerate
endmodule

// File: rtl/bmc_sram.sv
// Word array with a registered read port (one clock latency).
module bmc_sram #(
   parameter int DW = 32,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] q
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      q <= mem[raddr];
   end
endmodule

// File: rtl/bmc_fsm.sv
// Transfer sequencing: first word in two clocks, later beats in one.
module bmc_fsm
   import bmc_pkg::*;
#(
   parameter int LINE_BITS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_as,
   input  logic                 bus_ds,
   input  logic                 bus_rw,
   input  logic                 bus_burst_req,
   input  logic                 burstable,
   output logic                 start,
   output logic                 in_idle,
   output logic [LINE_BITS-1:0] beat,
   output logic                 ack,
   output logic                 grant,
   output logic                 read_oe
);
   localparam logic [LINE_BITS-1:0] LAST_BEAT = '1;

   bmc_state_e state;
   logic       cap_read;
   logic       granted;
   logic       keep_going;

   always_comb begin
      in_idle    = (state == ST_IDLE);
      start      = in_idle && bus_as && bus_ds;
      keep_going = bus_as && bus_burst_req;
      ack        = !in_idle;
      grant      = granted && !in_idle;
      read_oe    = ack && cap_read;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         beat     <= '0;
         cap_read <= 1'b0;
         granted  <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_FIRST;
                  beat     <= '0;
                  cap_read <= bus_rw;
                  granted  <= bus_rw && bus_burst_req && burstable;
               end
            end
            ST_FIRST: begin
               if (granted && keep_going) begin
                  state <= ST_BEAT;
                  beat  <= beat + 1'b1;
               end else begin
                  state   <= ST_IDLE;
                  granted <= 1'b0;
               end
            end
            ST_BEAT: begin
               if (!keep_going || beat == LAST_BEAT) begin
                  state   <= ST_IDLE;
                  granted <= 1'b0;
               end else begin
                  beat <= beat + 1'b1;
               end
            end
            default: begin
               state   <= ST_IDLE;
               granted <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/burst_mem_ctrl.sv
module burst_mem_ctrl #(
   parameter int          DW         = 32,
   parameter int          AW         = 32,
   parameter int          MEM_AW     = 6,
   parameter int          LINE_WORDS = 4,
   parameter bit          BURST_EN   = 1'b1,
   parameter logic [31:0] BURST_LO   = 32'h0000_0000,
   parameter logic [31:0] BURST_HI   = 32'h0000_007F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_as,
   input  logic          bus_ds,
   input  logic          bus_rw,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_burst_req,
   output logic [DW-1:0] rd_data,
   output logic          term_ack,
   output logic          burst_ack
);
   localparam int LINE_BITS = $clog2(LINE_WORDS);
   localparam int BYTE_BITS = $clog2(DW / 8);

   generate
      if (LINE_WORDS < 2 || (1 << LINE_BITS) != LINE_WORDS) begin : g_bad_line
         $error("LINE_WORDS must be a power of two of at least 2");
      end
      if (MEM_AW <= LINE_BITS) begin : g_bad_mem
         $error("MEM_AW must exceed the line index width");
      end
      if (DW != 32) begin : g_bad_dw
         $error("bus is fixed at 32 bits");
      end
      if (AW < MEM_AW + BYTE_BITS || AW > 32) begin : g_bad_aw
         $error("AW out of range");
      end
   endgenerate

   logic [MEM_AW-1:0]    bus_word;
   logic [MEM_AW-1:0]    cap_word;
   logic [MEM_AW-1:0]    next_word;
   logic [MEM_AW-1:0]    raddr;
   logic [DW-1:0]        mem_q;
   logic [LINE_BITS-1:0] beat;
   logic                 start;
   logic                 in_idle;
   logic                 burstable;
   logic                 ack;
   logic                 grant;
   logic                 read_oe;

   assign bus_word = bus_addr[MEM_AW+BYTE_BITS-1:BYTE_BITS];

   bmc_range_chk #(
      .AW(AW), .BURST_EN(BURST_EN), .LO(BURST_LO), .HI(BURST_HI)
   ) u_range (
      .addr(bus_addr), .burstable(burstable)
   );

   bmc_fsm #(.LINE_BITS(LINE_BITS)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
      .bus_burst_req(bus_burst_req), .burstable(burstable),
      .start(start), .in_idle(in_idle), .beat(beat),
      .ack(ack), .grant(grant), .read_oe(read_oe)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)     cap_word <= '0;
      else if (start) cap_word <= bus_word;
   end

   bmc_addr_gen #(.MEM_AW(MEM_AW), .LINE_BITS(LINE_BITS)) u_wrap (
      .base_word(cap_word), .offset(beat + 1'b1), .word(next_word)
   );

   assign raddr = in_idle ? bus_word : next_word;

   bmc_sram #(.DW(DW), .AW(MEM_AW)) u_mem (
      .clk(clk), .we(start && !bus_rw), .waddr(bus_word),
      .wdata(bus_wdata), .raddr(raddr), .q(mem_q)
   );

   assign rd_data   = read_oe ? mem_q : '0;
   assign term_ack  = ack;
   assign burst_ack = grant;
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_as,
   input logic          bus_ds,
   input logic          bus_rw,
   input logic          bus_burst_req,
   input logic [DW-1:0] rd_data,
   input logic          term_ack,
   input logic          burst_ack
);
   p_burst_in_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
      burst_ack |-> term_ack);

   p_single_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (term_ack && !burst_ack) |=> !term_ack);

   p_idle_data_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !term_ack |-> (rd_data == '0));

   p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_ack && (!bus_as || !bus_burst_req)) |=> (!term_ack && rd_data == '0));

   p_write_no_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_ack && bus_as && bus_ds && !bus_rw) |=> !burst_ack);

   p_no_req_no_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!term_ack && !bus_burst_req) |=> !burst_ack);

   p_line_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (term_ack && $past(term_ack) && $past(term_ack, 2) && $past(term_ack, 3))
      |=> !term_ack);
endmodule

bind burst_mem_ctrl bmc_checker #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_ds(bus_ds),
   .bus_rw(bus_rw), .bus_burst_req(bus_burst_req), .rd_data(rd_data),
   .term_ack(term_ack), .burst_ack(burst_ack)
);

// File: tb/sim_burst_mem_ctrl.sv
`timescale 1ns/1ps
module sim_burst_mem_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_as = 1'b0, bus_ds = 1'b0, bus_rw = 1'b1, bus_burst_req = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic [31:0] rd_data;
   logic        term_ack, burst_ack;

   int tests = 0;
   int fails = 0;
   logic [31:0] ref_mem [64];

   always #2.5 clk = ~clk;

   burst_mem_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_as(bus_as), .bus_ds(bus_ds),
      .bus_rw(bus_rw), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_burst_req(bus_burst_req), .rd_data(rd_data),
      .term_ack(term_ack), .burst_ack(burst_ack)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wrap_addr(input logic [31:0] a, input int k);
      logic [1:0] off;
      off = a[3:2] + k[1:0];
      return {a[31:4], off, 2'b00};
   endfunction

   function automatic bit exp_grant(input logic [31:0] a, input bit req);
      return req && (a <= 32'h7F);
   endfunction

   task automatic idle_bus();
      bus_as = 1'b0; bus_ds = 1'b0; bus_burst_req = 1'b0; bus_rw = 1'b1;
   endtask

   task automatic do_write(input logic [31:0] a, input logic [31:0] d, input bit req);
      int k;
      @(negedge clk);
      bus_as = 1'b1; bus_ds = 1'b1; bus_rw = 1'b0; bus_addr = a;
      bus_wdata = d; bus_burst_req = req;
      @(negedge clk);
      chk(term_ack === 1'b1 && burst_ack === 1'b0, "R3 write ack", {30'd0, term_ack, burst_ack}, 32'h2);
      idle_bus();
      @(negedge clk);
      chk(term_ack === 1'b0, "R4 write single ack", {31'd0, term_ack}, 32'd0);
      ref_mem[a[7:2]] = d;
      k = 0;
   endtask

   task automatic do_read(input logic [31:0] a);
      @(negedge clk);
      bus_as = 1'b1; bus_ds = 1'b1; bus_rw = 1'b1; bus_addr = a; bus_burst_req = 1'b0;
      @(negedge clk);
      chk(term_ack === 1'b1 && rd_data === ref_mem[a[7:2]], "R2 single read", rd_data, ref_mem[a[7:2]]);
      idle_bus();
      @(negedge clk);
      chk(term_ack === 1'b0 && rd_data === 32'd0, "R10 idle data zero", rd_data, 32'd0);
   endtask

   task automatic line_fill(input logic [31:0] a, input bit req);
      int k;
      int words;
      bit granted;
      bit exp_g;
      logic [31:0] want;
      exp_g = exp_grant(a, req);
      @(negedge clk);
      bus_as = 1'b1; bus_ds = 1'b1; bus_rw = 1'b1; bus_addr = a; bus_burst_req = req;
      k = 0; words = 0; granted = 1'b0;
      while (words < 4 && k < 40) begin
         @(negedge clk);
         k++;
         if (term_ack) begin
            want = ref_mem[wrap_addr(a, words) >> 2 & 32'h3F];
            chk(rd_data === want, "R7 wrap data", rd_data, want);
            if (words == 0) begin
               granted = burst_ack;
               chk(burst_ack === exp_g, "R5 grant decision", {31'd0, burst_ack}, {31'd0, exp_g});
            end else if (granted) begin
               chk(burst_ack === 1'b1, "R11 burst ack held", {31'd0, burst_ack}, 32'd1);
            end
            words++;
            if (!granted && words < 4) begin
               bus_addr = wrap_addr(a, words);
               bus_burst_req = 1'b0;
            end
         end
      end
      idle_bus();
      if (exp_g) chk(k + 1 == 5, "R6 burst clocks", k + 1, 5);
      else       chk(k + 1 == 8, "R8 fallback clocks", k + 1, 8);
   endtask

   initial begin
      #500000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(term_ack === 1'b0 && burst_ack === 1'b0 && rd_data === 32'd0, "R1 in reset",
          {term_ack, burst_ack, rd_data[29:0]}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(term_ack === 1'b0 && burst_ack === 1'b0 && rd_data === 32'd0, "R1 after reset",
          {term_ack, burst_ack, rd_data[29:0]}, 32'd0);

      for (int i = 0; i < 64; i++) do_write(i * 4, $urandom, i[0]);

      do_read(32'h0000_0010);
      do_read(32'h0000_0100 | 32'h3C);          // upper bits ignored, R2
      line_fill(32'h0000_0000, 1'b1);
      line_fill(32'h0000_0008, 1'b1);           // starts mid-line, R7
      line_fill(32'h0000_007C, 1'b1);           // top of window
      line_fill(32'h0000_0080, 1'b1);           // just outside window, R8
      line_fill(32'h0000_0024, 1'b0);           // no request, R8

      // R9: withdraw request after the first fast beat
      @(negedge clk);
      bus_as = 1'b1; bus_ds = 1'b1; bus_rw = 1'b1; bus_addr = 32'h14; bus_burst_req = 1'b1;
      @(negedge clk);
      chk(burst_ack === 1'b1, "R9 setup grant", {31'd0, burst_ack}, 32'd1);
      @(negedge clk);
      chk(term_ack === 1'b1, "R9 first beat", {31'd0, term_ack}, 32'd1);
      bus_burst_req = 1'b0;
      @(negedge clk);
      chk(term_ack === 1'b0 && rd_data === 32'd0, "R9 req abort", rd_data, 32'd0);
      idle_bus();
      @(negedge clk);
      chk(term_ack === 1'b0, "R9 stays idle", {31'd0, term_ack}, 32'd0);

      // R9: strobe drop in the grant clock
      bus_as = 1'b1; bus_ds = 1'b1; bus_rw = 1'b1; bus_addr = 32'h30; bus_burst_req = 1'b1;
      @(negedge clk);
      chk(burst_ack === 1'b1, "R9 setup grant2", {31'd0, burst_ack}, 32'd1);
      idle_bus(); bus_burst_req = 1'b1;
      @(negedge clk);
      chk(term_ack === 1'b0 && rd_data === 32'd0, "R9 strobe abort", rd_data, 32'd0);
      idle_bus();

      for (int n = 0; n < 80; n++) begin
         logic [31:0] a;
         int op;
         a = {24'd0, $urandom_range(0, 63) * 4};
         op = $urandom_range(0, 2);
         if (op == 0)      do_write(a, $urandom, $urandom_range(0, 1));
         else if (op == 1) do_read(a);
         else              line_fill(a, $urandom_range(0, 1));
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule